// File: doc/BRIEF.md
# Sequential Floating-Point Multiplier

This block multiplies two numbers held in a 32-bit word made of a biased exponent byte, a sign bit and a fraction whose leading one is implied. The exponents are added and the bias of 128 is removed. If the biased sum falls outside the byte range, the block flags overflow or returns zero. The two 24-bit mantissas, with their implied ones put back, are multiplied by shift-and-add at one multiplier bit per clock. A multiplier byte that is all zero is passed over in a single clock. Only the upper 32 bits of the product are kept. The product is normalised by at most one left shift and rounded on the guard byte below the fraction.

A caller presents both operands with a one-cycle `start` and waits for the one-cycle `done`. The result word and the overflow flag stay valid until the next completed operation. The block takes no new work while it is busy.

Top module: `flt_mul`

## Requirements
- R1: Word layout: bits [31:24] hold the exponent E biased by 128, bit 23 holds the sign, and bits [22:0] hold the fraction f. The value is (1/2 + f/2^24) * 2^(E-128). E = 0 denotes zero. If either operand has E = 0, the result is 0x00000000 and overflow is 0.
- R2: With S = Ea + Eb, S >= 384 sets overflow to 1 and leaves the result unspecified. S <= 128 gives result 0x00000000 with overflow 0. Otherwise the provisional exponent is S - 128.
- R3: For every nonzero, non-overflowing result, bit 23 equals the XOR of the two operand sign bits.
- R4: The mantissas Ma = 2^23 + fa and Mb = 2^23 + fb give the 32-bit product P = floor(Ma*Mb / 2^16).
- R5: If P[31] is 0, P is shifted left by one and the exponent is reduced by one. If that reduced exponent is 0, the result is 0x00000000 with overflow 0.
- R6: The result mantissa is P[31:8] + P[7]. A carry out of 24 bits gives mantissa 0x800000 and adds one to the exponent. Result bits [22:0] are the low 23 mantissa bits.
- R7: `done` is high for exactly one cycle. Take the edge that accepts `start` as edge 0. When R1 or R2 already decides the result, `done` rises at edge 1. Otherwise it rises at edge N+1, where N = 8 + c(op_b[7:0]) + c(op_b[15:8]), and c(x) is 1 when x = 0 and 8 otherwise.
- R8: A `start` that arrives while an operation is in progress has no effect. It starts nothing and changes nothing. The result and overflow outputs change only in the cycle where `done` is high and hold their values in between.
- R9: While reset is low at a clock edge, `done`, `result` and `overflow` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation with op_a and op_b (sampled while idle) |
| op_a | input | 32 | Multiplicand word |
| op_b | input | 32 | Multiplier word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product word, held until the next completion |
| overflow | output | 1 | Exponent out of range; held with result |

## Verification
A table of hand-worked products exercises the main path through several patterns:
- Exact powers of two check the bias arithmetic and the one-step normalisation.
- Mixed signs separate the sign logic from the magnitude.
- An all-ones fraction pair exposes truncation of the dropped product bits.
- A pair with the guard bit set tells rounding from truncation.
- A pair whose product rounds up into a carry shows that the mantissa resets to 0x800000 and the exponent is restored.

Exponent sums of 128, 129, 383 and 384 separate underflow, normalisation-driven underflow, the largest legal result and overflow. Multipliers with zero and nonzero low bytes distinguish the byte-skip timing from the bit-serial timing. A batch of pseudo-random operands is compared against an arithmetic model built from the requirements.

// File: rtl/flt_mul_pkg.sv
// Shared types for the sequential floating-point multiplier.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package flt_mul_pkg;

    // Control sequence of the multiplier.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_t;

    // Early outcome decided by the exponents alone.
    typedef struct packed {
        logic zero;
        logic ovf;
    } early_t;

endpackage

// File: rtl/flt_mul_exp.sv
// Exponent stage: adds the two biased exponents and removes the bias.
// The test for out-of-range sums compares the carry out of the addition
// with the top bit of the sum. Equal values mean overflow (both set) or
// underflow (both clear).
// Assumes: the bias is 2^(EXP_W-1); an exponent field of zero means zero.
module flt_mul_exp
    import flt_mul_pkg::*;
#(
    parameter int EXP_W = 8
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    output early_t           early,
    output logic [EXP_W-1:0] exp_sum
);

    logic [EXP_W:0] sum;
    logic           cy;
    logic           msb;
    logic           any_zero;

    // Purpose: raw sum plus range classification.
    always_comb begin
        sum      = {1'b0, exp_a} + {1'b0, exp_b};
        cy       = sum[EXP_W];
        msb      = sum[EXP_W-1];
        any_zero = (exp_a == '0) || (exp_b == '0);
        // Taking the bias off modulo 2^EXP_W flips the top bit.
        exp_sum    = {~msb, sum[EXP_W-2:0]};
        early.ovf  = !any_zero && cy && msb;
        early.zero = any_zero || (!cy && !msb) || ((cy != msb) && (exp_sum == '0));
    end

endmodule

// File: rtl/flt_mul_core.sv
// Shift-and-add mantissa multiplier. It handles one multiplier bit per
// cycle, least-significant first, with a right-shifting accumulator that
// keeps only the top PROD_W bits of the exact product. When SKIP_EN is
// set, an all-zero multiplier chunk at a chunk boundary is consumed in one
// cycle.
// Assumes: MANT_W is a multiple of CHUNK_W; load and run are never both high.
module flt_mul_core #(
    parameter int MANT_W  = 24,
    parameter int GUARD_W = 8,
    parameter int CHUNK_W = 8,
    parameter bit SKIP_EN = 1'b1,
    localparam int PROD_W = MANT_W + GUARD_W,
    localparam int HI_W   = MANT_W + 2,
    localparam int CNT_W  = $clog2(MANT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [MANT_W-1:0] mcand,
    input  logic [MANT_W-1:0] mplier,
    output logic [HI_W-1:0]   prod_hi,
    output logic              last
);

    logic [PROD_W-1:0] acc_q;
    logic [PROD_W-1:0] addend_q;
    logic [MANT_W-1:0] mq_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              skip;
    logic [PROD_W:0]   step_sum;
    logic [PROD_W-1:0] acc_d;
    logic [MANT_W-1:0] mq_d;
    logic [CNT_W-1:0]  cnt_d;

    // Variant pick: byte-skip detection present or tied off.
    generate
        if (SKIP_EN) begin : g_skip
            assign skip = ((cnt_q % CNT_W'(CHUNK_W)) == '0) && (mq_q[CHUNK_W-1:0] == '0);
        end else begin : g_noskip
            assign skip = 1'b0;
        end
    endgenerate

    // Purpose: next accumulator, multiplier and count for one cycle.
    always_comb begin
        step_sum = {1'b0, acc_q} + (mq_q[0] ? {1'b0, addend_q} : '0);
        if (skip) begin
            acc_d = acc_q >> CHUNK_W;
            mq_d  = mq_q >> CHUNK_W;
            cnt_d = cnt_q + CNT_W'(CHUNK_W);
        end else begin
            acc_d = step_sum[PROD_W:1];
            mq_d  = mq_q >> 1;
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    assign last    = run && (cnt_d == CNT_W'(MANT_W));
    assign prod_hi = acc_q[PROD_W-1 -: HI_W];

    // Purpose: load a new pair or advance the multiplication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            addend_q <= '0;
            mq_q     <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            acc_q    <= '0;
            addend_q <= {mcand, {GUARD_W{1'b0}}};
            mq_q     <= mplier;
            cnt_q    <= '0;
        end else if (run) begin
            acc_q <= acc_d;
            mq_q  <= mq_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/flt_mul_round.sv
// Normalise-and-round stage. It takes the top MANT_W+2 product bits, shifts
// left once when the leading bit is clear (lowering the exponent), then
// adds the guard bit. A mantissa carry resets the mantissa to its
// leading one and raises the exponent.
// Assumes: the product leading one sits in one of its two top bits.
module flt_mul_round #(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input  logic [MANT_W+1:0] prod_hi,
    input  logic [EXP_W-1:0]  exp_in,
    output logic [MANT_W-1:0] mant,
    output logic [EXP_W-1:0]  exp_out,
    output logic              uflow,
    output logic              oflow
);

    logic            shift;
    logic [MANT_W:0] norm;
    logic [MANT_W:0] rsum;
    logic            carry;
    logic [EXP_W-1:0] e1;

    // Purpose: one-step normalisation, guard rounding, exponent update.
    always_comb begin
        shift = !prod_hi[MANT_W+1];
        norm  = shift ? prod_hi[MANT_W:0] : prod_hi[MANT_W+1:1];
        rsum  = {1'b0, norm[MANT_W:1]} + (MANT_W+1)'(norm[0]);
        carry = rsum[MANT_W];
        mant  = carry ? {1'b1, {(MANT_W-1){1'b0}}} : rsum[MANT_W-1:0];
        e1    = exp_in - EXP_W'(shift);
        uflow = shift && (e1 == '0);
        {oflow, exp_out} = {1'b0, e1} + (EXP_W+1)'(carry);
    end

endmodule

// File: rtl/flt_mul.sv
// Sequential floating-point multiplier top. Word = {exponent, sign,
// fraction}, with an implied leading one in the fraction. Accepts start
// while idle, runs the mantissa core, then normalises, rounds and
// reports with a one-cycle done. Results with a zero operand or an
// out-of-range exponent finish without running the core.
// Assumes: synchronous active-low reset; operands are sampled only at start.
module flt_mul
    import flt_mul_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int MANT_W  = 24,
    parameter int GUARD_W = 8,
    parameter int CHUNK_W = 8,
    parameter bit SKIP_EN = 1'b1,
    localparam int WORD_W = EXP_W + MANT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              overflow
);

    localparam int SIGN_B = MANT_W - 1;

    mul_state_t        state_q;
    early_t            early_d;
    early_t            early_q;
    logic [EXP_W-1:0]  exp_d;
    logic [EXP_W-1:0]  exp_q;
    logic              sign_q;
    logic              accept;
    logic              last;
    logic [MANT_W+1:0] prod_hi;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  exp_fin;
    logic              r_uflow;
    logic              r_oflow;
    logic              done_q;
    logic [WORD_W-1:0] result_q;
    logic              ovf_q;

    assign accept = (state_q == ST_IDLE) && start;

    flt_mul_exp #(.EXP_W(EXP_W)) u_exp (
        .exp_a   (op_a[WORD_W-1:MANT_W]),
        .exp_b   (op_b[WORD_W-1:MANT_W]),
        .early   (early_d),
        .exp_sum (exp_d)
    );

    flt_mul_core #(
        .MANT_W  (MANT_W),
        .GUARD_W (GUARD_W),
        .CHUNK_W (CHUNK_W),
        .SKIP_EN (SKIP_EN)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .run     (state_q == ST_RUN),
        .mcand   ({1'b1, op_a[SIGN_B-1:0]}),
        .mplier  ({1'b1, op_b[SIGN_B-1:0]}),
        .prod_hi (prod_hi),
        .last    (last)
    );

    flt_mul_round #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_round (
        .prod_hi (prod_hi),
        .exp_in  (exp_q),
        .mant    (mant),
        .exp_out (exp_fin),
        .uflow   (r_uflow),
        .oflow   (r_oflow)
    );

    // Purpose: sequence idle -> run -> finish, capturing operand-side state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            early_q <= '0;
            exp_q   <= '0;
            sign_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    early_q <= early_d;
                    exp_q   <= exp_d;
                    sign_q  <= op_a[SIGN_B] ^ op_b[SIGN_B];
                    state_q <= (early_d.zero || early_d.ovf) ? ST_FIN : ST_RUN;
                end
                ST_RUN:  if (last) state_q <= ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: publish result and flag once per operation with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIN);
            if (state_q == ST_FIN) begin
                if (early_q.ovf || (!early_q.zero && r_oflow)) begin
                    ovf_q    <= 1'b1;
                    result_q <= '0;
                end else if (early_q.zero || r_uflow || !mant[MANT_W-1]) begin
                    ovf_q    <= 1'b0;
                    result_q <= '0;
                end else begin
                    ovf_q    <= 1'b0;
                    result_q <= {exp_fin, sign_q, mant[MANT_W-2:0]};
                end
            end
        end
    end

    assign done     = done_q;
    assign result   = result_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/flt_mul_chk.sv
// Property checker for flt_mul, attached by bind. Tracks the operation in
// flight from the ports only: it records the exponent and sign fields seen
// at an accepted start.
// Assumes: the same parameters as the bound instance.
module flt_mul_chk #(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24,
    localparam int WORD_W = EXP_W + MANT_W,
    localparam int BIAS   = 1 << (EXP_W - 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              overflow,
    input logic [WORD_W-1:0] result,
    input logic [EXP_W-1:0]  a_exp,
    input logic [EXP_W-1:0]  b_exp,
    input logic              a_sign,
    input logic              b_sign
);

    logic             busy_q;
    logic [EXP_W-1:0] ea_q;
    logic [EXP_W-1:0] eb_q;
    logic             sx_q;

    // Purpose: mirror which operation is in flight and what it was given.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ea_q   <= '0;
            eb_q   <= '0;
            sx_q   <= 1'b0;
        end else begin
            if (done) busy_q <= 1'b0;
            if (start && (!busy_q || done)) begin
                busy_q <= 1'b1;
                ea_q   <= a_exp;
                eb_q   <= b_exp;
                sx_q   <= a_sign ^ b_sign;
            end
        end
    end

    // R7: completion is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion only for an accepted operation.
    assert_done_has_job_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

    // R8: outputs hold between completions.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(overflow)));

    // R1: a zero operand yields a plain zero word.
    assert_zero_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((ea_q == '0) || (eb_q == '0))) |-> ((result == '0) && !overflow));

    // R2: overflow only for an exponent sum at or above three biases.
    assert_overflow_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (({1'b0, ea_q} + {1'b0, eb_q}) >= (EXP_W+1)'(3 * BIAS)));

    // R3: sign of a nonzero result is the XOR of the operand signs.
    assert_sign_xor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow && (result != '0)) |-> (result[MANT_W-1] == sx_q));

    // R5: a zero exponent field only ever appears in an all-zero word.
    assert_zero_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow && (result[WORD_W-1:MANT_W] == '0)) |-> (result == '0));

endmodule

bind flt_mul flt_mul_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .overflow (overflow),
    .result   (result),
    .a_exp    (op_a[WORD_W-1:MANT_W]),
    .b_exp    (op_b[WORD_W-1:MANT_W]),
    .a_sign   (op_a[MANT_W-1]),
    .b_sign   (op_b[MANT_W-1])
);

// File: tb/flt_mul_test.sv
`timescale 1ns/1ps
module flt_mul_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        done;
    logic [31:0] result;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    flt_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .done(done), .result(result), .overflow(overflow)
    );

    // {a, b, expected result, expected overflow}; results worked by hand
    localparam int NV = 15;
    localparam logic [96:0] VECS [NV] = '{
        {32'h80000000, 32'h80000000, 32'h7F000000, 1'b0}, // R4 R5 0.5*0.5
        {32'h81000000, 32'h81000000, 32'h81000000, 1'b0}, // R2 1*1
        {32'h81800000, 32'h81000000, 32'h81800000, 1'b0}, // R3 -1*1
        {32'h81800000, 32'h81800000, 32'h81000000, 1'b0}, // R3 -1*-1
        {32'h80400000, 32'h80400000, 32'h80100000, 1'b0}, // R4 0.75^2
        {32'h807FFFFF, 32'h807FFFFF, 32'h807FFFFE, 1'b0}, // R4 truncation
        {32'h80400000, 32'h80000001, 32'h7F400002, 1'b0}, // R6 guard round up
        {32'h807FFFFE, 32'h80000001, 32'h80000000, 1'b0}, // R6 mantissa carry
        {32'hFF7FFFFE, 32'h80000001, 32'hFF000000, 1'b0}, // R2 R6 sum 383
        {32'h00123456, 32'h81000000, 32'h00000000, 1'b0}, // R1 zero a
        {32'h81000000, 32'h00FFFFFF, 32'h00000000, 1'b0}, // R1 zero b
        {32'h40000000, 32'h40000000, 32'h00000000, 1'b0}, // R2 sum 128
        {32'h41000000, 32'h40000000, 32'h00000000, 1'b0}, // R5 sum 129
        {32'hFF000000, 32'h81000000, 32'h00000000, 1'b1}, // R2 sum 384
        {32'hC0000000, 32'hC0000000, 32'h00000000, 1'b1}  // R2 sum 384
    };

    // Arithmetic model written from R1..R6: {overflow, result}
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
        int          s, e;
        logic [63:0] p;
        logic [24:0] f;
        if (a[31:24] == 0 || b[31:24] == 0) return 33'd0;
        s = int'(a[31:24]) + int'(b[31:24]);
        if (s >= 384) return {1'b1, 32'd0};
        if (s <= 128) return 33'd0;
        e = s - 128;
        p = (({40'd0, 1'b1, a[22:0]} * {40'd0, 1'b1, b[22:0]}) >> 16);
        if (!p[31]) begin
            p = (p << 1) & 64'hFFFF_FFFF;
            e = e - 1;
            if (e == 0) return 33'd0;
        end
        f = {1'b0, p[31:8]} + {24'd0, p[7]};
        if (f[24]) begin
            f = 25'h0800000;
            e = e + 1;
            if (e > 255) return {1'b1, 32'd0};
        end
        return {1'b0, e[7:0], a[23] ^ b[23], f[22:0]};
    endfunction

    // Edge index of done per R7
    function automatic int model_lat(input logic [31:0] a, input logic [31:0] b);
        int s;
        s = int'(a[31:24]) + int'(b[31:24]);
        if (a[31:24] == 0 || b[31:24] == 0 || s >= 384 || s <= 128) return 1;
        return 8 + ((b[7:0] == 0) ? 1 : 8) + ((b[15:8] == 0) ? 1 : 8) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic o, output int lat);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 200);
        r = result;
        o = overflow;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        logic [31:0] r, held;
        logic        o;
        int          lat, ndone;
        logic [31:0] lf;
        logic [32:0] m;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R9", "done in reset", {31'd0, done}, 32'd0);
        check(result == 32'd0, "R9", "result in reset", result, 32'd0);
        check(overflow == 1'b0, "R9", "overflow in reset", {31'd0, overflow}, 32'd0);
        rst_n = 1'b1;

        // Table walk: R1..R7
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i][96:65], VECS[i][64:33], r, o, lat);
            check(o == VECS[i][0], "R2", $sformatf("overflow vec %0d", i), {31'd0, o}, {31'd0, VECS[i][0]});
            if (!VECS[i][0])
                check(r == VECS[i][32:1], "R4", $sformatf("result vec %0d", i), r, VECS[i][32:1]);
            check(lat == model_lat(VECS[i][96:65], VECS[i][64:33]), "R7",
                  $sformatf("latency vec %0d", i), lat, model_lat(VECS[i][96:65], VECS[i][64:33]));
        end

        // R7: one skipped low byte, one full byte
        run_op(32'h81000100, 32'h81000100, r, o, lat);
        check(lat == 18, "R7", "latency low byte zero", lat, 18);
        run_op(32'h81010101, 32'h81010101, r, o, lat);
        check(lat == 25, "R7", "latency no skip", lat, 25);

        // R8: start during operation ignored, outputs held afterwards
        @(negedge clk);
        op_a = 32'h81012345; op_b = 32'h81810101; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op_a = 32'h80000000; op_b = 32'h80000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        m = model(32'h81012345, 32'h81810101);
        check(result == m[31:0], "R8", "result of first start", result, m[31:0]);
        held = result;
        ndone = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check(ndone == 0, "R8", "no second completion", ndone, 0);
        check(result == held, "R8", "result held", result, held);

        // R3 R4 R5 R6: pseudo-random operands against the model
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 60; k++) begin
            logic [31:0] a, b;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            a = {8'(8'd100 + 8'(lf[31:24] % 8'd60)), lf[23:0]};
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            b = {8'(8'd100 + 8'(lf[31:24] % 8'd60)), lf[23:0]};
            if (k % 4 == 0) b[7:0] = 8'd0;
            m = model(a, b);
            run_op(a, b, r, o, lat);
            check(o == m[32], "R2", $sformatf("random overflow %0d", k), {31'd0, o}, {31'd0, m[32]});
            if (!m[32])
                check(r == m[31:0], "R6", $sformatf("random result %0d", k), r, m[31:0]);
            check(lat == model_lat(a, b), "R7", $sformatf("random latency %0d", k), lat, model_lat(a, b));
        end

        finish_up();
    end

endmodule